// File: doc/BRIEF.md
# Look-Ahead Pipelined Parallel Binary Counter

This block is a free-running synchronous up-counter with a plain binary output. The count is split into 2-bit slices that all update on the same clock edge. No carry ripples from slice to slice. The two least significant bits sit in a base slice that steps on every clock.

Each upper slice steps when two registered signals agree:
- a ready flop in the counting path, which holds the registered "all ones" state of the slice below;
- a timing pulse from a short chain of flip-flops. The chain is fed by a two-input decode of the base slice, taken early enough that the pulse leaves the chain exactly in the cycle the base slice holds 3.

As a result, the logic in front of every counter bit is one slice access plus one small AND, whatever the width.

The block has only a clock, a synchronous active-high reset and the count vector. The width is a parameter, even, from 4 to 8. The look-ahead chain lengths and the decoder taps are derived from the slice index.

Top module: `plc_lookahead_counter`

## Requirements
- R1: The base slice, which holds count bits [1:0], increments by one modulo 4 on every clock edge while reset is low.
- R2: The counting-path flop in front of upper slice 1 captures the decode "base slice equals 2". Upper slice 1 therefore steps on the same edge on which the base slice wraps from 3 to 0.
- R3: An upper slice j changes only on an edge where its counting-path ready flop and its look-ahead pulse are both high, and then it increments by one modulo 4. Otherwise it holds its value.
- R4: Upper slice j (j ≥ 2) has a look-ahead chain of j−1 flops, fed by a decoder of base value 4−j (value 2 for j=2, value 1 for j=3). The chain output is high only in cycles where the base slice equals 3.
- R5: In every cycle the count equals a plain binary reference counter. This includes the wrap from all ones to zero.
- R6: With reset high at an edge, the count and every pipeline and look-ahead flop clear to 0. The first edge after reset is released yields count 1.
- R7: From count 0b101000, seven further edges give 0b101001 through 0b101111. Bits [3:2] change on the edge from 0b101011 to 0b101100.
- R8: With WIDTH=4 the block is a 4-bit counter: base slice plus one upper slice, with no look-ahead chain. It follows the same reference modulo 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every flop updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears count and pipeline |
| count | output | WIDTH | Binary count value, readable every cycle |

## Verification
The assertions assume that reset is held high across the first clock edge. They also assume that reset only changes away from the active edge, so the pipeline always starts from the all-zero state that matches count 0. The stimulus raises reset from time zero, drives it only on falling edges, and applies it once more in the middle of a run to re-enter that consistent state. Apart from that, the counter takes no inputs. The stimulus is therefore a long free run over more than two full wraps of the 8-bit counter, with a 4-bit instance running beside it.

// File: rtl/plc_pkg.sv
package plc_pkg;

  localparam int SLICE_W = 2;
  localparam logic [SLICE_W-1:0] SLICE_TOP = 2'd3;

  // value of the base slice decoded into the ready flop of upper slice 1
  localparam logic [SLICE_W-1:0] FIRST_READY_TAP = 2'd2;

  // next value of a 2-bit counting slice
  function automatic logic [SLICE_W-1:0] slice_next(input logic [SLICE_W-1:0] v);
    return v + 2'd1;
  endfunction

  // two-input AND decode of a 2-bit slice against a fixed value
  function automatic logic slice_is(input logic [SLICE_W-1:0] v,
                                    input logic [SLICE_W-1:0] tap);
    return (v[1] ~^ tap[1]) & (v[0] ~^ tap[0]);
  endfunction

  // base-slice value a look-ahead chain for upper slice j must decode
  function automatic logic [SLICE_W-1:0] chain_tap(input int j);
    return SLICE_W'(4 - j);
  endfunction

  // number of flops in the look-ahead chain of upper slice j
  function automatic int chain_depth(input int j);
    return j - 1;
  endfunction

endpackage

// File: rtl/plc_base_slice.sv
module plc_base_slice
  import plc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [SLICE_W-1:0] q,
  output logic               at_top
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= slice_next(q);
  end

  assign at_top = slice_is(q, SLICE_TOP);

  // R1: free-running step modulo 4
  a_r1_base_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q == SLICE_W'($past(q) + 2'd1));

endmodule

// File: rtl/plc_ff_chain.sv
module plc_ff_chain #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/plc_upper_slice.sv
module plc_upper_slice
  import plc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               ready,
  output logic [SLICE_W-1:0] q,
  output logic               full_ready
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (go) q <= slice_next(q);
  end

  // this slice is all ones and every slice below it is too
  assign full_ready = slice_is(q, SLICE_TOP) & ready;

  // R3: holds without a step command
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(q));

  // R3: steps by one on a step command
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    go |=> q == SLICE_W'($past(q) + 2'd1));

endmodule

// File: rtl/plc_lookahead_counter.sv
module plc_lookahead_counter
  import plc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] count
);

  localparam int NUP = WIDTH / SLICE_W - 1;

  logic [SLICE_W-1:0] base_q;
  logic               base_top;

  logic [SLICE_W-1:0] up_q   [1:NUP];
  logic               ready  [1:NUP];
  logic               pulse  [1:NUP];
  logic               step   [1:NUP];
  logic               full_r [1:NUP];

  initial begin
    if (WIDTH < 4 || WIDTH > 8 || (WIDTH % 2) != 0)
      $error("plc_lookahead_counter: WIDTH must be even and within 4..8");
  end

  plc_base_slice u_base (
    .clk    (clk),
    .rst    (rst),
    .q      (base_q),
    .at_top (base_top)
  );

  assign count[SLICE_W-1:0] = base_q;

  genvar j;
  generate
    for (j = 1; j <= NUP; j++) begin : g_up
      logic ready_r;

      if (j == 1) begin : g_first
        // counting-path flop fed by the early decode of the base slice
        always_ff @(posedge clk) begin
          if (rst) ready_r <= 1'b0;
          else     ready_r <= slice_is(base_q, FIRST_READY_TAP);
        end
        assign pulse[j] = base_top;

        // R2: the first ready flop is only high while the base slice is 3
        a_r2_first_ready: assert property (@(posedge clk) disable iff (rst)
          ready_r |-> base_q == SLICE_TOP);
      end else begin : g_rest
        logic early;

        // counting-path flop fed by the slice below being full
        always_ff @(posedge clk) begin
          if (rst) ready_r <= 1'b0;
          else     ready_r <= full_r[j-1];
        end

        assign early = slice_is(base_q, chain_tap(j));

        plc_ff_chain #(.DEPTH(chain_depth(j))) u_chain (
          .clk (clk),
          .rst (rst),
          .d   (early),
          .q   (pulse[j])
        );

        // R4: the chain pulse lines up with base value 3
        a_r4_pulse_aligned: assert property (@(posedge clk) disable iff (rst)
          pulse[j] |-> base_q == SLICE_TOP);
      end

      assign ready[j] = ready_r;
      assign step[j]  = ready[j] & pulse[j];

      plc_upper_slice u_slice (
        .clk        (clk),
        .rst        (rst),
        .go         (step[j]),
        .ready      ((j == 1) ? 1'b1 : ready[j]),
        .q          (up_q[j]),
        .full_ready (full_r[j])
      );

      assign count[SLICE_W*j+1 : SLICE_W*j] = up_q[j];
    end
  endgenerate

  // R5: the whole vector behaves as a binary counter
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> count == WIDTH'($past(count) + 1'b1));

  // R6: a reset edge leaves the count at zero
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> count == '0);

endmodule

// File: tb/plc_lookahead_counter_tb.sv
`timescale 1ns/1ps
module plc_lookahead_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] count;
  logic [3:0] count4;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit rst_q[$];
  int model = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  plc_lookahead_counter #(.WIDTH(8)) dut_i (.clk(clk), .rst(rst), .count(count));
  plc_lookahead_counter #(.WIDTH(4)) dut4_i (.clk(clk), .rst(rst), .count(count4));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: sets reset for the next edge and records the expected count
  task automatic drive(input bit r);
    @(negedge clk);
    rst = r;
    if (r) model = 0;
    else   model = (model + 1) % 256;
    exp_q.push_back(model);
    rst_q.push_back(r);
  endtask

  // monitor: compares after each rising edge
  initial begin
    int prev;
    bit have_prev;
    have_prev = 1'b0;
    prev = 0;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        int e;
        bit r;
        e = exp_q.pop_front();
        r = rst_q.pop_front();
        if (r) begin
          chk("R6 reset clears count", int'(count), 0);
        end else begin
          if (e == 0) chk("R5 wrap to zero", int'(count), e);
          else if (e >= 8'b101001 && e <= 8'b101111)
            chk("R7 directed run", int'(count), e);
          else if (e[3:0] == 4'b0000)
            chk("R4 slice 2 step", int'(count), e);
          else if (e[1:0] == 2'b00)
            chk("R2 slice 1 step on wrap", int'(count), e);
          else
            chk("R5 reference match", int'(count), e);
          chk("R1 base slice", int'(count[1:0]), e % 4);
          if (have_prev && e[1:0] != 2'b00)
            chk("R3 upper bits hold", int'(count[7:2]), prev >> 2);
        end
        chk("R8 four-bit width", int'(count4), e % 16);
        prev = int'(count);
        have_prev = !r;
      end else if (done) begin
        break;
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) drive(1'b1);
    for (int i = 0; i < 300; i++) drive(1'b0);
    for (int i = 0; i < 2; i++) drive(1'b1);
    for (int i = 0; i < 600; i++) drive(1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule